// File: doc/BRIEF.md
# Dual-Buffer Receive Frame Store with Destination Filter

This block is the receive half of a compact Ethernet MAC. Frame bytes arrive one per cycle on a valid/last byte stream (preamble and frame check sequence already removed by the surrounding logic). The first six bytes are held back until the destination address can be judged. A frame that passes is written into the currently selected receive buffer. When its last byte arrives, that buffer is marked full. Frames addressed elsewhere are discarded quietly. Frames that find the current buffer still full, and frames that grow too long, are dropped and flagged on a one-cycle status pulse.

Two buffers sit in a 32-bit, word-addressed register window. Each buffer has one control word holding a full flag and an interrupt-enable flag. Software reads a stored frame, then releases the buffer by writing its control word with the full flag at zero. With `PINGPONG=1` the block alternates between the buffers after every stored frame, so one frame can be read while the next is being received. With `PINGPONG=0` it always uses buffer 0.

Top module: `eth_rx_pingpong`

## Requirements
- R1: A frame passes the filter when bit 7 of its first byte is set, or when its first six bytes equal `station_mac_i` (first byte compared with bits 47:40). A frame that fails the filter changes no control word, raises no `irq_o` and no `drop_o`.
- R2: A frame that passes the filter while the current buffer's full flag is set is dropped. `drop_o` is high for exactly the one cycle after the sixth byte is sampled. No control word changes and no interrupt is raised.
- R3: A passing frame that reaches `MAX_LEN` (default 2020) bytes is dropped. `drop_o` pulses in the cycle after the `MAX_LEN`-th byte is sampled, and no full flag is set. A frame of `MAX_LEN-1` bytes is stored.
- R4: Byte k of a stored frame is placed in buffer word k/4, lane k%4, at bits 8*(k%4)+7 down to 8*(k%4). Buffer 0 words start at byte offset 0x1000 and buffer 1 words at 0x1800. Unused lanes of the final word read as zero.
- R5: The cycle after the last byte of a stored frame is sampled, the full flag (control bit 0) of the buffer that received the frame is set.
- R6: In that same cycle `irq_o` is high for one cycle, but only if that buffer's interrupt-enable flag (control bit 3) is set and `irq_en_i` is high.
- R7: With `PINGPONG=1`, the current buffer alternates 0, 1, 0, … after every stored frame. Dropped or filtered frames leave it unchanged.
- R8: A bus write to a control word (0x17FC for buffer 0, 0x1FFC for buffer 1) loads the full flag from data bit 0 and the enable flag from bit 3, and ignores the other bits. A read returns the two flags in those bit positions with zeros elsewhere, one cycle after the request.
- R9: A frame that ends before its sixth byte is discarded silently: no write, no flag change, no pulse.
- R10: After reset both control words read zero, `irq_o` and `drop_o` are low, and buffer 0 is the current buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received frame byte |
| rx_valid_i | input | 1 | Byte on `rx_data_i` is valid |
| rx_last_i | input | 1 | Valid byte is the final byte of the frame |
| station_mac_i | input | 48 | Station address; bits 47:40 are the first byte on the wire |
| irq_en_i | input | 1 | Global interrupt enable |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | Bus access is a write |
| bus_addr_i | input | 13 | Byte address in the receive window |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | One-cycle frame-stored interrupt |
| drop_o | output | 1 | One-cycle pulse for a frame lost to a full buffer or to excess length |

## Verification
The bench targets the following cases:
- A frame of exactly six bytes stored at the filter decision. A design that writes the header word and the final word in the same cycle loses one of them.
- A frame one byte short of the length limit, and one that reaches it exactly. An off-by-one in the length limit stores the over-long frame or drops the legal one.
- A frame for this station that meets a full buffer. It must pulse `drop_o`, while a frame for another station must stay quiet. Swapping the filter and the full check shows up as a spurious or missing pulse.
- Frames shorter than six bytes, and a stream with idle gaps inside frames. A design that decides early, or that counts idle cycles as bytes, corrupts the buffer or the flags.
- An interrupt-enable flag that is clear, and a global enable that is low. A missing gate on either shows up as a stray `irq_o`.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  typedef enum logic [1:0] {
    RX_HDR  = 2'd0,  // collecting destination bytes
    RX_ACC  = 2'd1,  // accepted, storing
    RX_SKIP = 2'd2   // discarding until last
  } rx_mode_e;

  localparam int CTL_FULL_BIT = 0;
  localparam int CTL_IEN_BIT  = 3;
  localparam int MAC_BYTES    = 6;
endpackage

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import eth_rx_pkg::*;
(
  input  logic [8*MAC_BYTES-1:0] dst_i,
  input  logic [8*MAC_BYTES-1:0] mac_i,
  output logic                   pass_o
);
  logic [MAC_BYTES-1:0] byte_eq;

  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_cmp
    assign byte_eq[g] = (dst_i[8*g +: 8] == mac_i[8*g +: 8]);
  end

  // group bit of the first byte on the wire, or exact station match
  assign pass_o = dst_i[8*MAC_BYTES-1] | (&byte_eq);
endmodule

// File: rtl/rx_buf_ram.sv
module rx_buf_ram #(
  parameter int NBUF = 2,
  parameter int WA   = 9
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [$clog2(NBUF)-1:0] wsel_i,
  input  logic [WA-1:0]           waddr_i,
  input  logic [31:0]             wdata_i,
  input  logic                    re_i,
  input  logic [$clog2(NBUF)-1:0] rsel_i,
  input  logic [WA-1:0]           raddr_i,
  output logic [31:0]             rdata_o
);
  localparam int SW    = $clog2(NBUF);
  localparam int DEPTH = NBUF * (2 ** WA);

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[{wsel_i, waddr_i}] <= wdata_i;
    if (re_i) rdata_o <= mem[{rsel_i, raddr_i}];
  end

  logic [SW-1:0] unused_sw;
  assign unused_sw = '0;
endmodule

// File: rtl/rx_ctrl_regs.sv
module rx_ctrl_regs #(
  parameter int NBUF = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NBUF-1:0] wr_i,
  input  logic            wfull_i,
  input  logic            wien_i,
  input  logic [NBUF-1:0] set_i,
  output logic [NBUF-1:0] full_o,
  output logic [NBUF-1:0] ien_o
);
  logic [NBUF-1:0] full_q, ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
      ien_q  <= '0;
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        if (wr_i[i]) begin
          full_q[i] <= wfull_i;
          ien_q[i]  <= wien_i;
        end
        // frame completion wins over a same-cycle software release
        if (set_i[i]) full_q[i] <= 1'b1;
      end
    end
  end

  assign full_o = full_q;
  assign ien_o  = ien_q;

  for (genvar g = 0; g < NBUF; g++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> full_q[g]);                                  // R5
    AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_q[g] && !wr_i[g] |=> full_q[g]);                     // R8
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import eth_rx_pkg::*;
#(
  parameter int MAX_LEN = 2020,
  parameter int WA      = 9,
  parameter int CNT_W   = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    data_i,
  input  logic          valid_i,
  input  logic          last_i,
  input  logic [47:0]   mac_i,
  input  logic          cur_full_i,
  output logic          ram_we_o,
  output logic [WA-1:0] ram_addr_o,
  output logic [31:0]   ram_data_o,
  output logic          fin_o,
  output logic          drop_o
);
  localparam logic [CNT_W-1:0] C_W0   = CNT_W'(3);
  localparam logic [CNT_W-1:0] C_DEC  = CNT_W'(MAC_BYTES - 1);
  localparam logic [CNT_W-1:0] C_LIM  = CNT_W'(MAX_LEN - 1);
  localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);

  rx_mode_e         mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [39:0]      hdr_q, hdr_d;
  logic [31:0]      acc_q, acc_d, acc_nxt, w0_q, w0_d;
  logic             fin_q, fin_d, drop_q, drop_d;
  logic [WA-1:0]    fin_addr_q, fin_addr_d;
  logic [31:0]      fin_data_q, fin_data_d;
  logic             byte_we;
  logic [WA-1:0]    byte_addr, widx;
  logic [31:0]      byte_data;
  logic [1:0]       lane;
  logic             pass;

  assign lane = cnt_q[1:0];
  assign widx = WA'(cnt_q >> 2);
  assign acc_nxt = (lane == 2'd0) ? {24'd0, data_i}
                 : (acc_q | ({24'd0, data_i} << {lane, 3'b000}));

  rx_dest_filter u_filter (
    .dst_i  ({hdr_q, data_i}),
    .mac_i  (mac_i),
    .pass_o (pass)
  );

  always_comb begin
    mode_d     = mode_q;
    cnt_d      = cnt_q;
    hdr_d      = hdr_q;
    acc_d      = acc_q;
    w0_d       = w0_q;
    fin_d      = 1'b0;
    fin_addr_d = fin_addr_q;
    fin_data_d = fin_data_q;
    drop_d     = 1'b0;
    byte_we    = 1'b0;
    byte_addr  = widx;
    byte_data  = acc_nxt;
    if (valid_i) begin
      acc_d = acc_nxt;
      unique case (mode_q)
        RX_HDR: begin
          cnt_d = cnt_q + C_ONE;
          hdr_d = {hdr_q[31:0], data_i};
          if (cnt_q == C_W0) w0_d = acc_nxt;
          if (cnt_q == C_DEC) begin
            if (!pass) begin
              mode_d = RX_SKIP;
            end else if (cur_full_i) begin
              drop_d = 1'b1;
              mode_d = RX_SKIP;
            end else begin
              mode_d    = RX_ACC;
              byte_we   = 1'b1;      // release the held first word
              byte_addr = '0;
              byte_data = w0_q;
              if (last_i) begin
                fin_d      = 1'b1;
                fin_addr_d = WA'(1);
                fin_data_d = acc_nxt;
              end
            end
          end
        end
        RX_ACC: begin
          cnt_d = cnt_q + C_ONE;
          if (cnt_q == C_LIM) begin
            drop_d = 1'b1;
            mode_d = RX_SKIP;
          end else if (last_i) begin
            fin_d      = 1'b1;
            fin_addr_d = widx;
            fin_data_d = acc_nxt;
          end else if (lane == 2'd3) begin
            byte_we = 1'b1;
          end
        end
        default: ;
      endcase
      if (last_i) begin
        mode_d = RX_HDR;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= RX_HDR;
      cnt_q      <= '0;
      hdr_q      <= '0;
      acc_q      <= '0;
      w0_q       <= '0;
      fin_q      <= 1'b0;
      fin_addr_q <= '0;
      fin_data_q <= '0;
      drop_q     <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      cnt_q      <= cnt_d;
      hdr_q      <= hdr_d;
      acc_q      <= acc_d;
      w0_q       <= w0_d;
      fin_q      <= fin_d;
      fin_addr_q <= fin_addr_d;
      fin_data_q <= fin_data_d;
      drop_q     <= drop_d;
    end
  end

  // final word is written in the completion cycle
  assign ram_we_o   = byte_we | fin_q;
  assign ram_addr_o = fin_q ? fin_addr_q : byte_addr;
  assign ram_data_o = fin_q ? fin_data_q : byte_data;
  assign fin_o      = fin_q;
  assign drop_o     = drop_q;

  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fin_q && byte_we));                                       // R4
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == RX_ACC) |-> (cnt_q <= C_LIM));                   // R3
  AST_DROP_NOT_FIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_q |-> !fin_q);                                         // R2
endmodule

// File: rtl/eth_rx_pingpong.sv
module eth_rx_pingpong
  import eth_rx_pkg::*;
#(
  parameter int MAX_LEN  = 2020,
  parameter int ADDR_W   = 13,
  parameter int PINGPONG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_last_i,
  input  logic [47:0]       station_mac_i,
  input  logic              irq_en_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              drop_o
);
  localparam int NBUF  = 2;
  localparam int WA    = ADDR_W - 4;            // words per buffer slot
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [WA-1:0] CTL_WORD = {WA{1'b1}};

  logic            cur_q, fin, irq_q;
  logic [NBUF-1:0] full, ien, ctl_wr, set_full;
  logic            in_rx, b_sel, is_ctl, rd_req;
  logic [WA-1:0]   b_word;
  logic            ram_we;
  logic [WA-1:0]   ram_addr;
  logic [31:0]     ram_wdata, ram_rdata, ctl_word;
  logic            rd_rx_q, rd_ctl_q;
  logic [31:0]     ctl_snap_q;

  // window decode: top bit selects receive half, next bit the buffer
  assign in_rx  = bus_addr_i[ADDR_W-1];
  assign b_sel  = bus_addr_i[ADDR_W-2];
  assign b_word = bus_addr_i[ADDR_W-3:2];
  assign is_ctl = (b_word == CTL_WORD);
  assign rd_req = bus_req_i & ~bus_we_i & in_rx;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    assign ctl_wr[g]   = bus_req_i & bus_we_i & in_rx & is_ctl & (b_sel == 1'(g));
    assign set_full[g] = fin & (cur_q == 1'(g));
  end

  rx_frame_fsm #(
    .MAX_LEN (MAX_LEN),
    .WA      (WA),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (rx_data_i),
    .valid_i    (rx_valid_i),
    .last_i     (rx_last_i),
    .mac_i      (station_mac_i),
    .cur_full_i (full[cur_q]),
    .ram_we_o   (ram_we),
    .ram_addr_o (ram_addr),
    .ram_data_o (ram_wdata),
    .fin_o      (fin),
    .drop_o     (drop_o)
  );

  rx_ctrl_regs #(.NBUF(NBUF)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctl_wr),
    .wfull_i (bus_wdata_i[CTL_FULL_BIT]),
    .wien_i  (bus_wdata_i[CTL_IEN_BIT]),
    .set_i   (set_full),
    .full_o  (full),
    .ien_o   (ien)
  );

  rx_buf_ram #(.NBUF(NBUF), .WA(WA)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .wsel_i  (cur_q),
    .waddr_i (ram_addr),
    .wdata_i (ram_wdata),
    .re_i    (rd_req & ~is_ctl),
    .rsel_i  (b_sel),
    .raddr_i (b_word),
    .rdata_o (ram_rdata)
  );

  if (PINGPONG != 0) begin : g_pp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cur_q <= 1'b0;
      else if (fin) cur_q <= ~cur_q;
    end
    AST_CUR_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fin |=> (cur_q != $past(cur_q)));                         // R7
  end else begin : g_single
    assign cur_q = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= fin & ien[cur_q] & irq_en_i;
  end
  assign irq_o = irq_q;

  always_comb begin
    ctl_word               = '0;
    ctl_word[CTL_FULL_BIT] = full[b_sel];
    ctl_word[CTL_IEN_BIT]  = ien[b_sel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_rx_q    <= 1'b0;
      rd_ctl_q   <= 1'b0;
      ctl_snap_q <= '0;
    end else if (bus_req_i & ~bus_we_i) begin
      rd_rx_q    <= in_rx;
      rd_ctl_q   <= is_ctl;
      ctl_snap_q <= ctl_word;
    end
  end

  assign bus_rdata_o = !rd_rx_q ? 32'd0 : (rd_ctl_q ? ctl_snap_q : ram_rdata);

  logic unused_bus;
  assign unused_bus = ^{bus_wdata_i[31:4], bus_wdata_i[2:1], bus_addr_i[1:0]};

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);                                          // R6
  AST_IRQ_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|full));                                         // R6
  AST_DROP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> !drop_o);                                        // R2
endmodule

// File: tb/eth_rx_pingpong_tb.sv
`timescale 1ns/1ps
module eth_rx_pingpong_tb;
  localparam int MAX_LEN = 2020;
  localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, irq_en = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, drop;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eth_rx_pingpong #(.MAX_LEN(MAX_LEN), .ADDR_W(13), .PINGPONG(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_last_i(rx_last), .station_mac_i(MAC), .irq_en_i(irq_en),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq), .drop_o(drop)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] mb [2][2048];
  logic [7:0] fq[$];
  logic [7:0] fr[$];
  bit m_full[2], m_ien[2];
  int m_cur, m_mode;
  bit m_fin, e_irq, e_drop;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_full = '{0, 0}; m_ien = '{0, 0};
      m_cur = 0; m_mode = 0; m_fin = 0; e_irq = 0; e_drop = 0;
      fq.delete();
    end else begin
      bit old_full;
      old_full = m_full[m_cur];
      e_irq = 0; e_drop = 0;
      if (bus_req && bus_we && bus_addr[12] && bus_addr[10:2] == 9'h1FF) begin
        m_full[bus_addr[11]] = bus_wdata[0];
        m_ien[bus_addr[11]]  = bus_wdata[3];
      end
      if (m_fin) begin
        int n;
        n = fr.size();
        for (int k = 0; k < n; k++) mb[m_cur][k] = fr[k];
        for (int k = n; k % 4 != 0; k++) mb[m_cur][k] = 8'h00;
        m_full[m_cur] = 1;
        e_irq = m_ien[m_cur] && irq_en;
        m_cur ^= 1;
        m_fin = 0;
      end
      if (rx_valid) begin
        fq.push_back(rx_data);
        if (m_mode == 0 && fq.size() == 6) begin
          bit pass;
          pass = fq[0][7] || ({fq[0], fq[1], fq[2], fq[3], fq[4], fq[5]} == MAC);
          if (!pass) m_mode = 2;
          else if (old_full) begin e_drop = 1; m_mode = 2; end
          else m_mode = 1;
        end else if (m_mode == 1 && fq.size() == MAX_LEN) begin
          e_drop = 1; m_mode = 2;
        end
        if (rx_last) begin
          if (m_mode == 1) begin fr = fq; m_fin = 1; end
          fq.delete();
          m_mode = 0;
        end
      end
    end
  end

  // per-cycle output comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks += 2;
      if (irq !== e_irq) begin
        fails++;
        $display("FAIL R6 irq_o actual=%0b expected=%0b at %0t", irq, e_irq, $time);
      end
      if (drop !== e_drop) begin
        fails++;
        $display("FAIL R2/R3 drop_o actual=%0b expected=%0b at %0t", drop, e_drop, $time);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic bus_wr(input logic [12:0] a, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [12:0] a, input logic [31:0] exp, input string tag);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
    @(negedge clk);
  endtask

  task automatic rd_ctl(input int b, input string tag);
    logic [31:0] e;
    e = '0; e[0] = m_full[b]; e[3] = m_ien[b];
    bus_rd(13'h17FC + 13'(b * 13'h800), e, tag);
  endtask

  task automatic rd_word(input int b, input int w, input string tag);
    bus_rd(13'h1000 + 13'(b * 13'h800) + 13'(4 * w),
           {mb[b][4*w+3], mb[b][4*w+2], mb[b][4*w+1], mb[b][4*w]}, tag);
  endtask

  task automatic send(input logic [47:0] dst, input int len, input int seed, input bit gap);
    for (int k = 0; k < len; k++) begin
      rx_valid = 1;
      rx_data  = (k < 6) ? dst[47-8*k -: 8] : 8'(seed + 3 * k);
      rx_last  = (k == len - 1);
      @(negedge clk);
      if (gap && (k % 5 == 4) && k != len - 1) begin
        rx_valid = 0; rx_last = 0;
        @(negedge clk);
      end
    end
    rx_valid = 0; rx_last = 0;
    repeat (3) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R5 watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int b = 0; b < 2; b++) for (int k = 0; k < 2048; k++) mb[b][k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    bus_rd(13'h17FC, 32'h0, "R10 ctrl0 after reset");
    bus_rd(13'h1FFC, 32'h0, "R10 ctrl1 after reset");

    bus_wr(13'h17FC, 32'h0000_0008);
    bus_wr(13'h1FFC, 32'hFFFF_FFF6);              // bit0=0, bit3=0? no: 0x6 -> I=0
    bus_rd(13'h1FFC, 32'h0, "R8 other bits ignored");
    bus_wr(13'h1FFC, 32'hFFFF_FFF8);
    bus_rd(13'h17FC, 32'h8, "R8 ctrl0 enable");
    bus_rd(13'h1FFC, 32'h8, "R8 ctrl1 enable, high bits dropped");
    irq_en = 1;

    send(MAC, 64, 5, 0);                          // buffer 0
    bus_rd(13'h17FC, 32'h9, "R5 buffer0 full");
    for (int w = 0; w < 16; w++) rd_word(0, w, "R4 buffer0 data");

    send(48'hFF_FF_FF_FF_FF_FF, 7, 9, 1);         // buffer 1
    bus_rd(13'h1FFC, 32'h9, "R7 second frame in buffer1");
    rd_word(1, 0, "R4 buffer1 word0");
    rd_word(1, 1, "R4 buffer1 partial word1");

    send(MAC, 20, 11, 0);                         // buffer 0 busy
    bus_rd(13'h17FC, 32'h9, "R2 buffer0 unchanged");
    rd_word(0, 2, "R2 buffer0 data kept");

    send(48'h02_11_22_33_44_56, 30, 13, 0);       // other station
    rd_ctl(0, "R1 filtered frame ctrl0");
    rd_ctl(1, "R1 filtered frame ctrl1");

    bus_wr(13'h17FC, 32'h8);
    bus_rd(13'h17FC, 32'h8, "R8 release buffer0");
    send(MAC, MAX_LEN - 1, 17, 0);                // longest legal frame
    bus_rd(13'h17FC, 32'h9, "R3 max-length frame stored");
    rd_word(0, 0, "R3 long frame word0");
    rd_word(0, (MAX_LEN - 2) / 4, "R3 long frame last word");

    bus_wr(13'h1FFC, 32'h0);
    send(MAC, MAX_LEN, 19, 0);                    // too long
    bus_rd(13'h1FFC, 32'h0, "R3 oversize not stored");
    send(MAC, 6, 23, 0);                          // decision byte is last
    bus_rd(13'h1FFC, 32'h1, "R6 buffer1 full without irq");
    rd_word(1, 0, "R4 six-byte word0");
    rd_word(1, 1, "R4 six-byte word1 zero lanes");

    bus_wr(13'h17FC, 32'h8);
    send(MAC, 3, 29, 0);
    send(MAC, 5, 31, 1);
    bus_rd(13'h17FC, 32'h8, "R9 short frames ignored");

    send(48'h81_00_00_00_00_01, 10, 37, 1);       // group bit
    bus_rd(13'h17FC, 32'h9, "R1 group address accepted");
    rd_word(0, 2, "R1 group frame data");

    irq_en = 0;
    bus_wr(13'h1FFC, 32'h8);
    send(MAC, 12, 41, 0);
    bus_rd(13'h1FFC, 32'h9, "R6 global enable low, still stored");
    rd_ctl(0, "R7 buffer0 untouched by buffer1 frame");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule